// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches eight general-purpose input lines and turns chosen activity on them into interrupt requests for one port. Every line can sense either a level or an edge. A second bit picks the active level or the active edge direction. Each line also has an enable bit and an optional debounce filter. Inputs cross into the clock domain through a two-flop synchroniser. Edges are found by comparing each filtered sample with the one before it. A detected edge on an edge-mode line is held in a pending flag until software clears that flag through a write-one-to-clear acknowledge register. A level-mode line shows as pending for as long as its input sits at the active level.

Software uses a small byte-wide register bus with a write strobe, an address and write data. Read data is combinational from the address. The status register shows the pending lines masked by the enable register, and the port interrupt output is high whenever any status bit is set. To reconfigure a line safely, software clears its enable bit, writes the polarity register, then the sense register, and then enables the line again.

The debounce filter for each line is a two-state machine. Its states are DB_STEADY (the accepted level matches the synchronised input, or debounce is off) and DB_SETTLE (a different level has been seen on at least one sample tick). It has four transitions. STEADY goes to SETTLE on a tick that sees a mismatch. SETTLE goes to STEADY on a tick that sees the old level again, and the count is discarded. SETTLE goes to STEADY, taking the new level, on the third consecutive mismatching tick. Either state goes to STEADY when debounce is switched off. A free-running prescaler issues one sample tick every TICK_DIV clocks.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register (sense, polarity, enable, debounce), every pending flag, the status byte and `irq_out` read as zero.
- R2: A change on `pin_in` first reaches the status byte after the second rising clock edge that follows it. The change is not visible after the first edge.
- R3: A line whose sense bit is 0 is level sensed. It is pending exactly while its conditioned input equals its polarity bit (polarity 1 = active high, 0 = active low).
- R4: A line whose sense bit is 1 is edge sensed. A rising edge (polarity 1) or a falling edge (polarity 0) of the conditioned input sets the line's pending flag, and the flag stays set after the input returns.
- R5: A bus write of data D to the acknowledge address clears the pending flag of every line whose bit in D is 1. Zero bits leave flags unchanged, level-sensed lines are unaffected, and an edge detected in the same cycle as its acknowledge stays pending.
- R6: Status bit i equals line i's pending condition ANDed with enable bit i. An edge that arrives while a line is disabled is not recorded and does not appear when the line is enabled later.
- R7: `irq_out` is 1 exactly when at least one status bit is 1.
- R8: With debounce bit i set, line i's conditioned input takes a new level only after three consecutive sample ticks (one every TICK_DIV = 4 clocks, counting from reset) all see that level. Shorter pulses are ignored. With the bit clear, the synchronised input is used directly.
- R9: Address map: 0 = sense, 1 = polarity, 2 = acknowledge (write-only, reads 0), 3 = enable, 4 = debounce, 5 = status (read-only, writes ignored), 6 and 7 read 0. Registers 0, 1, 3 and 4 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | LINES | Raw input lines, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | LINES | Register write data, one bit per line |
| bus_rdata | output | LINES | Register read data for bus_addr (combinational) |
| irq_out | output | 1 | Combined port interrupt request |

## Verification
A lost or stuck pending flag shows on `irq_out` and in the status byte on the very next clock. A wrong edge-history bit shows as a spurious or missing pending flag one clock after the input moves. A debounce machine stuck in the wrong state or with a miscounted tick total changes when the status byte follows a pin, by a whole tick period or more. Because of that, the bench compares status and interrupt against its model on every clock rather than only at the end of a scenario. Register decode faults show at once in the read data or as a wrong mask in the status byte.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_SENSE    = 3'd0,
        REG_POLAR    = 3'd1,
        REG_ACK      = 3'd2,
        REG_ENABLE   = 3'd3,
        REG_DEBOUNCE = 3'd4,
        REG_STATUS   = 3'd5
    } reg_addr_e;

    typedef enum logic {
        DB_STEADY = 1'b0,
        DB_SETTLE = 1'b1
    } db_state_e;
endpackage

// File: rtl/gpint_tick.sv
module gpint_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt <= '0;
                else if (cnt == LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == LAST);

            // R8: sample ticks are never back to back when the divider exceeds one
            p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/gpint_line_cond.sv
module gpint_line_cond
    import gpint_pkg::*;
#(
    parameter int SETTLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic tick,
    input  logic deb_en,
    output logic level
);
    localparam int CW     = $clog2(SETTLE_TICKS + 1);
    localparam int LAST_I = SETTLE_TICKS - 1;
    localparam logic [CW-1:0] LAST = CW'(LAST_I);

    logic meta_q, sync_q;
    db_state_e state_q, state_nx;
    logic [CW-1:0] cnt_q, cnt_nx;
    logic held_q, held_nx;

    // two-flop synchroniser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_STEADY;
            cnt_q   <= '0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            held_q  <= held_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        held_nx  = held_q;
        if (!deb_en) begin
            state_nx = DB_STEADY;
            cnt_nx   = '0;
            held_nx  = sync_q;
        end else begin
            unique case (state_q)
                DB_STEADY: begin
                    if (tick && (sync_q != held_q)) begin
                        if (SETTLE_TICKS <= 1) begin
                            held_nx = sync_q;
                        end else begin
                            state_nx = DB_SETTLE;
                            cnt_nx   = CW'(1);
                        end
                    end
                end
                DB_SETTLE: begin
                    if (tick) begin
                        if (sync_q == held_q) begin
                            state_nx = DB_STEADY;
                            cnt_nx   = '0;
                        end else if (cnt_q == LAST) begin
                            state_nx = DB_STEADY;
                            cnt_nx   = '0;
                            held_nx  = sync_q;
                        end else begin
                            cnt_nx = cnt_q + 1'b1;
                        end
                    end
                end
                default: state_nx = DB_STEADY;
            endcase
        end
    end

    // output logic
    always_comb begin
        level = deb_en ? held_q : sync_q;
    end

    // R8: the accepted level cannot move between sample ticks while filtering
    p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (deb_en && !tick) |=> $stable(held_q));
endmodule

// File: rtl/gpint_event_latch.sv
module gpint_event_latch #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] level,
    input  logic [LINES-1:0] sense,
    input  logic [LINES-1:0] polar,
    input  logic [LINES-1:0] enable,
    input  logic [LINES-1:0] ack,
    output logic [LINES-1:0] pend
);
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] rise, fall, hit;

    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        hit  = sense & enable & ((polar & rise) | (~polar & fall));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= level;
            pend   <= (pend & ~ack) | hit;
        end
    end

    // R5: an acknowledged flag with no new edge is clear on the next cycle
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack & ~hit) != '0) |=> ((pend & $past(ack & ~hit)) == '0));

    // R4 / R6: a flag may only appear on an enabled edge-sensed line
    p_set_needs_edge_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(sense & enable)) == '0));

    // R4: a flag drops only when acknowledged
    p_flag_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend & $past(pend) & ~$past(ack)) == '0));
endmodule

// File: rtl/gpint_regs.sv
module gpint_regs
    import gpint_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  status,
    output logic [LINES-1:0]  rdata,
    output logic [LINES-1:0]  sense,
    output logic [LINES-1:0]  polar,
    output logic [LINES-1:0]  enable,
    output logic [LINES-1:0]  deb_en,
    output logic [LINES-1:0]  ack
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense  <= '0;
            polar  <= '0;
            enable <= '0;
            deb_en <= '0;
        end else if (wr) begin
            case (addr)
                REG_SENSE:    sense  <= wdata;
                REG_POLAR:    polar  <= wdata;
                REG_ENABLE:   enable <= wdata;
                REG_DEBOUNCE: deb_en <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        ack = (wr && (addr == REG_ACK)) ? wdata : '0;
    end

    always_comb begin
        case (addr)
            REG_SENSE:    rdata = sense;
            REG_POLAR:    rdata = polar;
            REG_ENABLE:   rdata = enable;
            REG_DEBOUNCE: rdata = deb_en;
            REG_STATUS:   rdata = status;
            default:      rdata = '0;
        endcase
    end

    // R9: a write to the status address leaves every configuration register alone
    p_status_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == REG_STATUS)) |=> $stable({sense, polar, enable, deb_en}));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpint_pkg::*;
#(
    parameter int LINES        = 8,
    parameter int TICK_DIV     = 4,
    parameter int SETTLE_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    output logic              irq_out
);
    logic             tick;
    logic [LINES-1:0] level, pend, status;
    logic [LINES-1:0] sense, polar, enable, deb_en, ack;

    gpint_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpint_line_cond #(.SETTLE_TICKS(SETTLE_TICKS)) u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[i]),
            .tick  (tick),
            .deb_en(deb_en[i]),
            .level (level[i])
        );
    end

    gpint_event_latch #(.LINES(LINES)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level),
        .sense (sense),
        .polar (polar),
        .enable(enable),
        .ack   (ack),
        .pend  (pend)
    );

    gpint_regs #(.LINES(LINES)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .status(status),
        .rdata (bus_rdata),
        .sense (sense),
        .polar (polar),
        .enable(enable),
        .deb_en(deb_en),
        .ack   (ack)
    );

    always_comb begin
        status  = enable & ((sense & pend) | (~sense & ~(level ^ polar)));
        irq_out = |status;
    end
endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
    localparam int LINES    = 8;
    localparam int TICK_DIV = 4;
    localparam int SETTLE   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd5;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_irq_detect #(.LINES(LINES), .TICK_DIV(TICK_DIV), .SETTLE_TICKS(SETTLE)) i_gpio_irq_detect (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_ff1, m_s, m_filt, m_prev, m_latch, m_t1, m_t2, m_en, m_db;
    int m_dcnt [8];
    int m_tcnt;

    function automatic logic [7:0] m_level();
        return (m_db & m_filt) | (~m_db & m_s);
    endfunction

    function automatic logic [7:0] m_status();
        logic [7:0] lv;
        lv = m_level();
        return m_en & ((m_t1 & m_latch) | (~m_t1 & ~(lv ^ m_t2)));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ff1 = 0; m_s = 0; m_filt = 0; m_prev = 0; m_latch = 0;
            m_t1 = 0; m_t2 = 0; m_en = 0; m_db = 0; m_tcnt = 0;
            foreach (m_dcnt[k]) m_dcnt[k] = 0;
        end else begin
            bit tk;
            logic [7:0] lv, hit, ack;
            tk  = (m_tcnt == TICK_DIV - 1);
            lv  = m_level();
            hit = m_t1 & m_en & ((m_t2 & lv & ~m_prev) | (~m_t2 & ~lv & m_prev));
            ack = (bus_wr && bus_addr == 3'd2) ? bus_wdata : 8'h00;
            m_latch = (m_latch & ~ack) | hit;
            m_prev  = lv;
            for (int i = 0; i < 8; i++) begin
                if (!m_db[i]) begin
                    m_filt[i] = m_s[i];
                    m_dcnt[i] = 0;
                end else if (tk) begin
                    if (m_s[i] != m_filt[i]) begin
                        if (m_dcnt[i] + 1 >= SETTLE) begin
                            m_filt[i] = m_s[i];
                            m_dcnt[i] = 0;
                        end else begin
                            m_dcnt[i] = m_dcnt[i] + 1;
                        end
                    end else begin
                        m_dcnt[i] = 0;
                    end
                end
            end
            m_s   = m_ff1;
            m_ff1 = pin_in;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_t1 = bus_wdata;
                    3'd1: m_t2 = bus_wdata;
                    3'd3: m_en = bus_wdata;
                    3'd4: m_db = bus_wdata;
                    default: ;
                endcase
            end
            m_tcnt = tk ? 0 : m_tcnt + 1;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 irq vs model", {7'd0, irq_out}, {7'd0, |m_status()});
            if (!bus_wr && bus_addr == 3'd5)
                check("R3/R4/R5/R6/R8 status vs model", bus_rdata, m_status());
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 3'd5; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_addr = 3'd5;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
        for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 register after reset");

        // configure: disable, polarity, sense, enable (lines 0-3 level, 4-7 edge)
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hAA);
        wr(3'd0, 8'hF0);
        wr(3'd3, 8'hFF);
        rd(3'd0, 8'hF0, "R9 sense readback");
        rd(3'd1, 8'hAA, "R9 polarity readback");
        rd(3'd3, 8'hFF, "R9 enable readback");
        rd(3'd2, 8'h00, "R9 ack reads zero");
        rd(3'd6, 8'h00, "R9 unused address 6");
        rd(3'd7, 8'h00, "R9 unused address 7");
        // pins low: active-low lines 0 and 2 pending
        rd(3'd5, 8'h05, "R3 level active-low lines pending");
        check("R7 irq high with pending line", {7'd0, irq_out}, 8'h01);

        // R2: line 1 (active high) rises; visible only after the second edge
        @(posedge clk); #1 pin_in[1] = 1'b1;
        @(negedge clk); check("R2 before first edge", bus_rdata & 8'h02, 8'h00);
        @(negedge clk); check("R2 after first edge", bus_rdata & 8'h02, 8'h00);
        @(negedge clk); check("R2 after second edge", bus_rdata & 8'h02, 8'h02);
        @(posedge clk); #1 pin_in[1] = 1'b0;
        idle(4);

        // R4: edges on lines 4-7 (5,7 rising; 4,6 falling)
        pin_in[7:4] = 4'hF; idle(5);
        rd(3'd5, 8'hA5, "R4 rising edges latched");
        pin_in[7:4] = 4'h0; idle(5);
        rd(3'd5, 8'hF5, "R4 falling edges latched and rising held");

        // R5: acknowledge
        wr(3'd2, 8'h30); idle(1);
        rd(3'd5, 8'hC5, "R5 ack clears selected lines");
        wr(3'd2, 8'h00); idle(1);
        rd(3'd5, 8'hC5, "R5 ack of zero changes nothing");
        wr(3'd2, 8'h0F); idle(1);
        rd(3'd5, 8'hC5, "R5 ack on level lines has no effect");
        wr(3'd2, 8'hC0); idle(1);
        rd(3'd5, 8'h05, "R5 remaining flags cleared");

        // R5: edge on line 5 in the same cycle as its acknowledge
        @(posedge clk); #1 pin_in[5] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h20;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 3'd5; bus_wdata = '0;
        rd(3'd5, 8'h25, "R5 edge wins over simultaneous ack");
        wr(3'd2, 8'h20);
        pin_in[5] = 1'b0; idle(4);
        rd(3'd5, 8'h05, "R4 falling edge ignored on rising line");

        // R6: edge while disabled is not recorded
        wr(3'd3, 8'h7F);
        pin_in[7] = 1'b1; idle(5);
        rd(3'd5, 8'h05, "R6 disabled line not pending");
        wr(3'd3, 8'hFF); idle(1);
        rd(3'd5, 8'h05, "R6 no stale event after enable");
        pin_in[7] = 1'b0; idle(4);

        // R7: all disabled
        wr(3'd3, 8'h00); idle(1);
        check("R7 irq low when all disabled", {7'd0, irq_out}, 8'h00);
        rd(3'd5, 8'h00, "R6 status masked by enable");
        wr(3'd3, 8'hFF); idle(1);

        // R9: status is read-only
        wr(3'd5, 8'hFF); idle(1);
        rd(3'd0, 8'hF0, "R9 status write leaves sense");
        rd(3'd5, 8'h05, "R9 status write ignored");

        // R8: debounce on line 0 (active low)
        wr(3'd4, 8'h01); idle(3);
        rd(3'd4, 8'h01, "R8 debounce readback");
        pin_in[0] = 1'b1; idle(2); pin_in[0] = 1'b0; idle(16);
        rd(3'd5, 8'h05, "R8 short pulse filtered");
        pin_in[0] = 1'b1; idle(6);
        rd(3'd5, 8'h05, "R8 new level not yet accepted");
        idle(24);
        rd(3'd5, 8'h04, "R8 stable level accepted");
        // without debounce the same short pulse on line 1 shows
        pin_in[1] = 1'b1; idle(2); pin_in[1] = 1'b0; idle(6);
        rd(3'd5, 8'h04, "R3 level line returns idle");

        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule